// File: doc/BRIEF.md
# On-Screen Display Overlay Mixer

This block lays a simple eight-colour on-screen display over the main video stream just ahead of the video encoder. The main pixel comes in as a luminance value plus two signed colour-difference values. With it, on the same system clock, come three single-bit OSD colour inputs (red, green, blue) and an overlay switch bit. When the switch is low, the main pixel goes through unchanged. When the switch is high, the block drops the main pixel and sends out a fixed palette colour chosen by the three colour bits.

The palette is fixed. White sits at a luminance of 162 and black at 66, both with zero colour difference. Black also serves as the border colour: an upstream character generator draws an outline by raising the switch with all colour bits low on the pixels around a glyph. The six saturated colours use luminance values between these two levels and colour-difference values in standard colour-bar proportions. The block does not generate characters, store fonts or time the outlines.

The switch bit and the main pixel pass through the same two register stages. The overlay therefore acts on exactly the pixel that was sampled with it. Values are given for `DATA_W` = 8. Wider paths carry the same codes left-aligned, and `DATA_W` must be at least 8.

Top module: `osd_overlay_mixer`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `pix_y_o` = 0, `pix_u_o` = 0 and `pix_v_o` = 0.
- R2: The latency is two clock edges. Inputs sampled at edge k show on the outputs right after edge k+2.
- R3: With `ovl_en_i` low, the outputs equal the main pixel (`pix_y_i`, `pix_u_i`, `pix_v_i`) sampled on the same edge, whatever the colour bits are.
- R4: With `ovl_en_i` high and colour code {`ovl_r_i`,`ovl_g_i`,`ovl_b_i`} = 3'b000 (black, also used as the border), the outputs are Y=66, U=0, V=0.
- R5: With `ovl_en_i` high and code 3'b111 (white), the outputs are Y=162, U=0, V=0.
- R6: With `ovl_en_i` high, the saturated colours (Y, U, V, with U and V in two's complement) are: red 3'b100 = (95, -14, 59); green 3'b010 = (122, -28, -49); blue 3'b001 = (77, 42, -10); yellow 3'b110 = (151, -42, 10); cyan 3'b011 = (133, 14, -59); magenta 3'b101 = (106, 28, 49). Every overlay luminance lies in 66..162.
- R7: A switch bit that changes from one pixel to the next acts only on the pixel sampled with it. Alternating border and character pixels come out in the same alignment.
- R8: With `ovl_en_i` high, the main pixel value has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_y_i | input | DATA_W | Main pixel luminance, unsigned |
| pix_u_i | input | DATA_W | Main pixel blue colour difference, two's complement |
| pix_v_i | input | DATA_W | Main pixel red colour difference, two's complement |
| ovl_r_i | input | 1 | OSD red bit |
| ovl_g_i | input | 1 | OSD green bit |
| ovl_b_i | input | 1 | OSD blue bit |
| ovl_en_i | input | 1 | Overlay switch: high replaces the main pixel |
| pix_y_o | output | DATA_W | Mixed luminance, registered |
| pix_u_o | output | DATA_W | Mixed blue colour difference, registered |
| pix_v_o | output | DATA_W | Mixed red colour difference, registered |

## Verification
The overlay switch and a main pixel change can land on the same clock edge, and the switch can also toggle on every pixel while the colour code changes too. The bench forces both: it changes the main pixel on every pixel, toggles the switch on every pixel, and runs border/character/border sequences. A behavioural model with a two-deep queue predicts each output. Every cycle is compared against that model, so a result that lands one pixel early or late, or that mixes the main pixel into an overlay pixel, shows up as a mismatch.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

  localparam int unsigned PAL_W = 8;

  typedef enum logic [2:0] {
    OC_BLACK   = 3'b000,
    OC_BLUE    = 3'b001,
    OC_GREEN   = 3'b010,
    OC_CYAN    = 3'b011,
    OC_RED     = 3'b100,
    OC_MAGENTA = 3'b101,
    OC_YELLOW  = 3'b110,
    OC_WHITE   = 3'b111
  } osd_code_t;

  typedef struct packed {
    logic [PAL_W-1:0] y;
    logic [PAL_W-1:0] u;
    logic [PAL_W-1:0] v;
  } pal_entry_t;

  localparam logic [PAL_W-1:0] LUMA_DARK  = 8'd66;
  localparam logic [PAL_W-1:0] LUMA_LIGHT = 8'd162;

  function automatic pal_entry_t pal_lookup(input osd_code_t code);
    pal_entry_t e;
    case (code)
      OC_BLACK:   e = '{y: LUMA_DARK,  u: 8'd0,    v: 8'd0};
      OC_WHITE:   e = '{y: LUMA_LIGHT, u: 8'd0,    v: 8'd0};
      OC_RED:     e = '{y: 8'd95,      u: 8'hF2,   v: 8'd59};
      OC_GREEN:   e = '{y: 8'd122,     u: 8'hE4,   v: 8'hCF};
      OC_BLUE:    e = '{y: 8'd77,      u: 8'd42,   v: 8'hF6};
      OC_YELLOW:  e = '{y: 8'd151,     u: 8'hD6,   v: 8'd10};
      OC_CYAN:    e = '{y: 8'd133,     u: 8'd14,   v: 8'hC5};
      OC_MAGENTA: e = '{y: 8'd106,     u: 8'd28,   v: 8'd49};
      default:    e = '{y: LUMA_DARK,  u: 8'd0,    v: 8'd0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/osd_sampler.sv
module osd_sampler #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W-1:0]       y_i,
  input  logic [DATA_W-1:0]       u_i,
  input  logic [DATA_W-1:0]       v_i,
  input  logic [2:0]              code_i,
  input  logic                    en_i,
  output logic [DATA_W-1:0]       y_q,
  output logic [DATA_W-1:0]       u_q,
  output logic [DATA_W-1:0]       v_q,
  output osd_mix_pkg::osd_code_t  code_q,
  output logic                    en_q
);
  import osd_mix_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q    <= '0;
      u_q    <= '0;
      v_q    <= '0;
      code_q <= OC_BLACK;
      en_q   <= 1'b0;
    end else begin
      y_q    <= y_i;
      u_q    <= u_i;
      v_q    <= v_i;
      code_q <= osd_code_t'(code_i);
      en_q   <= en_i;
    end
  end

endmodule

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int unsigned DATA_W = 8
) (
  input  osd_mix_pkg::osd_code_t code_i,
  output logic [DATA_W-1:0]      y_o,
  output logic [DATA_W-1:0]      u_o,
  output logic [DATA_W-1:0]      v_o
);
  import osd_mix_pkg::*;

  localparam int unsigned PAD = DATA_W - PAL_W;

  pal_entry_t ent;
  assign ent = pal_lookup(code_i);

  generate
    if (PAD == 0) begin : g_native
      assign y_o = ent.y;
      assign u_o = ent.u;
      assign v_o = ent.v;
    end else begin : g_wide
      assign y_o = {ent.y, {PAD{1'b0}}};
      assign u_o = {ent.u, {PAD{1'b0}}};
      assign v_o = {ent.v, {PAD{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/osd_select.sv
module osd_select #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_q,
  input  logic [2:0]        code_q,
  input  logic [DATA_W-1:0] main_y,
  input  logic [DATA_W-1:0] main_u,
  input  logic [DATA_W-1:0] main_v,
  input  logic [DATA_W-1:0] pal_y,
  input  logic [DATA_W-1:0] pal_u,
  input  logic [DATA_W-1:0] pal_v,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] u_o,
  output logic [DATA_W-1:0] v_o
);
  localparam int unsigned PAD = DATA_W - 8;
  localparam logic [DATA_W-1:0] Y_DARK  = DATA_W'(66)  << PAD;
  localparam logic [DATA_W-1:0] Y_LIGHT = DATA_W'(162) << PAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o <= '0;
      u_o <= '0;
      v_o <= '0;
    end else if (en_q) begin
      y_o <= pal_y;
      u_o <= pal_u;
      v_o <= pal_v;
    end else begin
      y_o <= main_y;
      u_o <= main_u;
      v_o <= main_v;
    end
  end

  // R3: switch low passes the sampled main pixel
  assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (y_o == $past(main_y) && u_o == $past(main_u) && v_o == $past(main_v)));

  // R4: black/border code
  assert_black_R4: assert property (@(posedge clk) disable iff (rst)
    (en_q && code_q == 3'b000) |=> (y_o == Y_DARK && u_o == '0 && v_o == '0));

  // R5: white code
  assert_white_R5: assert property (@(posedge clk) disable iff (rst)
    (en_q && code_q == 3'b111) |=> (y_o == Y_LIGHT && u_o == '0 && v_o == '0));

  // R6: overlay luminance stays within the dark..light span
  assert_luma_span_R6: assert property (@(posedge clk) disable iff (rst)
    en_q |=> (y_o >= Y_DARK && y_o <= Y_LIGHT));

endmodule

// File: rtl/osd_overlay_mixer.sv
module osd_overlay_mixer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pix_y_i,
  input  logic [DATA_W-1:0] pix_u_i,
  input  logic [DATA_W-1:0] pix_v_i,
  input  logic              ovl_r_i,
  input  logic              ovl_g_i,
  input  logic              ovl_b_i,
  input  logic              ovl_en_i,
  output logic [DATA_W-1:0] pix_y_o,
  output logic [DATA_W-1:0] pix_u_o,
  output logic [DATA_W-1:0] pix_v_o
);
  import osd_mix_pkg::*;

  localparam int unsigned PAD = DATA_W - PAL_W;
  localparam logic [DATA_W-1:0] Y_LIGHT = DATA_W'(162) << PAD;

  logic [DATA_W-1:0] s_y, s_u, s_v;
  logic [DATA_W-1:0] p_y, p_u, p_v;
  osd_code_t         s_code;
  logic              s_en;

  osd_sampler #(.DATA_W(DATA_W)) u_sample (
    .clk    (clk),
    .rst    (rst),
    .y_i    (pix_y_i),
    .u_i    (pix_u_i),
    .v_i    (pix_v_i),
    .code_i ({ovl_r_i, ovl_g_i, ovl_b_i}),
    .en_i   (ovl_en_i),
    .y_q    (s_y),
    .u_q    (s_u),
    .v_q    (s_v),
    .code_q (s_code),
    .en_q   (s_en)
  );

  osd_palette #(.DATA_W(DATA_W)) u_pal (
    .code_i (s_code),
    .y_o    (p_y),
    .u_o    (p_u),
    .v_o    (p_v)
  );

  osd_select #(.DATA_W(DATA_W)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .en_q   (s_en),
    .code_q (s_code),
    .main_y (s_y),
    .main_u (s_u),
    .main_v (s_v),
    .pal_y  (p_y),
    .pal_u  (p_u),
    .pal_v  (p_v),
    .y_o    (pix_y_o),
    .u_o    (pix_u_o),
    .v_o    (pix_v_o)
  );

  // cycles since reset, so two-deep history checks never reach into reset
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)               warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1: reset clears the outputs
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (pix_y_o == '0 && pix_u_o == '0 && pix_v_o == '0));

  // R2: two-edge latency on the main path
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && !$past(ovl_en_i, 2)) |->
      (pix_y_o == $past(pix_y_i, 2) && pix_v_o == $past(pix_v_i, 2)));

  // R7: the switch acts on the pixel sampled with it
  assert_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(ovl_en_i, 2) && $past(ovl_r_i, 2) &&
     $past(ovl_g_i, 2) && $past(ovl_b_i, 2)) |-> (pix_y_o == Y_LIGHT));

endmodule

// File: tb/osd_overlay_mixer_test.sv
module osd_overlay_mixer_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] y_i = '0, u_i = '0, v_i = '0;
  logic         r_i = 1'b0, g_i = 1'b0, b_i = 1'b0, en_i = 1'b0;
  logic [W-1:0] y_o, u_o, v_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  osd_overlay_mixer #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst),
    .pix_y_i(y_i), .pix_u_i(u_i), .pix_v_i(v_i),
    .ovl_r_i(r_i), .ovl_g_i(g_i), .ovl_b_i(b_i), .ovl_en_i(en_i),
    .pix_y_o(y_o), .pix_u_o(u_o), .pix_v_o(v_o)
  );

  // reference queue: entry {valid, tag, y, u, v}
  typedef struct {bit ok; string tag; int y; int u; int v;} exp_t;
  exp_t q[$];

  function automatic exp_t model(bit en, bit r, bit g, bit b,
                                 int y, int u, int v, string tag);
    exp_t e;
    e.ok = 1'b1; e.tag = tag;
    if (!en) begin
      e.y = y; e.u = u; e.v = v;
    end else begin
      case ({r, g, b})
        3'b000: begin e.y = 66;  e.u = 0;   e.v = 0;   end
        3'b111: begin e.y = 162; e.u = 0;   e.v = 0;   end
        3'b100: begin e.y = 95;  e.u = -14; e.v = 59;  end
        3'b010: begin e.y = 122; e.u = -28; e.v = -49; end
        3'b001: begin e.y = 77;  e.u = 42;  e.v = -10; end
        3'b110: begin e.y = 151; e.u = -42; e.v = 10;  end
        3'b011: begin e.y = 133; e.u = 14;  e.v = -59; end
        default: begin e.y = 106; e.u = 28; e.v = 49;  end
      endcase
    end
    e.u = e.u & 8'hFF;
    e.v = e.v & 8'hFF;
    return e;
  endfunction

  task automatic compare(exp_t e);
    total++;
    if (int'(y_o) != e.y || int'(u_o) != e.u || int'(v_o) != e.v) begin
      bad++;
      $display("FAIL %s: got y=%0d u=%0d v=%0d expected y=%0d u=%0d v=%0d",
               e.tag, y_o, u_o, v_o, e.y, e.u, e.v);
    end
  endtask

  // one pixel: check the output due now, then drive the next input
  task automatic step(bit en, bit r, bit g, bit b,
                      int y, int u, int v, string tag);
    exp_t e;
    @(negedge clk);
    if (q.size() == 2) begin
      e = q.pop_front();
      if (e.ok) compare(e);
    end
    en_i = en; r_i = r; g_i = g; b_i = b;
    y_i = W'(y); u_i = W'(u); v_i = W'(v);
    q.push_back(model(en, r, g, b, y, u & 8'hFF, v & 8'hFF, tag));
  endtask

  task automatic flush();
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R2");
  endtask

  initial begin
    exp_t z;
    // R1: outputs held at zero during reset, inputs busy
    en_i = 1'b1; r_i = 1'b1; g_i = 1'b1; b_i = 1'b1; y_i = 8'd200;
    repeat (3) @(negedge clk);
    z.ok = 1'b1; z.tag = "R1"; z.y = 0; z.u = 0; z.v = 0;
    compare(z);
    @(negedge clk);
    compare(z);
    rst = 1'b0;
    en_i = 1'b0; y_i = '0; u_i = '0; v_i = '0;
    z.ok = 1'b0;
    q.push_back(z);

    // R2/R3: pass-through with varying main pixel and arbitrary colour bits
    for (int i = 0; i < 24; i++)
      step(1'b0, i[0], i[1], i[2], (i * 37 + 5) & 255, (i * 91) & 255,
           (255 - i * 13) & 255, "R3");

    // R4 R5 R6 R8: every code, main pixel changing underneath
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 3; k++)
        step(1'b1, c[2], c[1], c[0], (c * 29 + k * 71) & 255,
             (k * 113) & 255, (c * 7 + 200) & 255,
             (c == 0) ? "R4" : (c == 7) ? "R5" : "R6");

    // R8: fixed code, main pixel swept
    for (int i = 0; i < 16; i++)
      step(1'b1, 1'b1, 1'b0, 1'b1, i * 16, 255 - i * 16, i * 9, "R8");

    // R7: switch toggles every pixel, main pixel changes every pixel
    for (int i = 0; i < 20; i++)
      step(i[0], 1'b1, 1'b1, 1'b1, (i * 11 + 3) & 255, i * 5, i * 3, "R7");

    // R7: border/character/border glyph rows between background pixels
    for (int row = 0; row < 4; row++) begin
      step(1'b0, 1'b1, 1'b0, 1'b0, 40 + row, 1, 2, "R7");
      step(1'b1, 1'b0, 1'b0, 1'b0, 41, 3, 4, "R7");
      step(1'b1, 1'b1, 1'b1, 1'b1, 42, 5, 6, "R7");
      step(1'b1, 1'b1, 1'b1, 1'b1, 43, 7, 8, "R7");
      step(1'b1, 1'b0, 1'b0, 1'b0, 44, 9, 10, "R7");
      step(1'b0, 1'b1, 1'b1, 1'b0, 45, 11, 12, "R7");
    end

    // R2: pixel with distinct value then flush to see it two edges later
    step(1'b0, 1'b0, 1'b0, 1'b0, 123, 45, 67, "R2");
    flush();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule